// File: doc/BRIEF.md
# Dual-Identifier I2C Register Target

This block is the serial target side of a two-wire bus for a small timekeeping device. It watches the clock and data lines through two-flop synchronisers and finds START and STOP conditions. It shifts in bytes MSB first on rising clock edges and pulls the data line low in the ninth clock to acknowledge a byte. During reads it shifts stored bytes out. The data output is open-drain: `sda_oe` high pulls the line low, and `sda_oe` low releases it.

Two fixed 7-bit identifiers are answered. One opens a 256-byte control/status space and the other opens a 256-byte user SRAM. The two spaces hold separate storage. A single byte-wide word pointer addresses both spaces. It is loaded by the address byte of a write and steps by one after each byte moved. It survives from one transaction to the next, so a read that carries no address phase continues from where the last transfer ended.

Top module: `dual_id_i2c_target`

## Requirements
- R1: Identifier 7'b1101111 (byte 8'hDE write / 8'hDF read) is acknowledged and selects the control/status space. Identifier 7'b1010111 (8'hAE / 8'hAF) is acknowledged and selects the user SRAM. A byte written to one space at a given address does not change the other space at that address.
- R2: Any other identifier is not acknowledged, and the target keeps SDA released until the next START. Bytes clocked in after such an identifier change no stored byte.
- R3: The target drives SDA low during the ninth clock after a matching identifier byte, after the word-address byte, and after every data byte of a write. Bytes are sent MSB first; bit 0 of the identifier byte is 1 for read and 0 for write.
- R4: Each data byte of a write is stored at the pointer. After each byte written or read, the pointer advances by one and wraps from 8'hFF to 8'h00.
- R5: Reset clears the pointer to 8'h00 and leaves stored bytes unchanged, so a read with no address phase first returns location 8'h00.
- R6: A random read (write-direction identifier, word address, repeated START, read-direction identifier) returns the bytes starting at the given address, from the space that was selected.
- R7: In a random read, a read-phase identifier that differs from the address-phase identifier is not acknowledged.
- R8: During a read the target sends another byte after each master ACK. After a master NACK it releases SDA and does not drive it again until a new START.
- R9: A START or STOP in the middle of a byte abandons that byte, and a partly received write byte is not stored.
- R10: `sda_oe` is low after reset and after a STOP, and it only changes while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples the bus |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Serial clock line from the bus |
| sda_i | input | 1 | Serial data line as seen on the bus |
| sda_oe | output | 1 | 1 pulls the data line low, 0 releases it |

## Verification
The hardest state to reach is the random-read check. A read-direction identifier is judged against the identifier of the address phase only when a repeated START comes between the two with no STOP. The bench's master task therefore issues START again straight from the low phase after the address ACK and uses the other space's identifier, so the NACK can come only from that comparison. A mid-byte STOP is reached with a partial-bit task that clocks four bits of a write byte before the stop. A read-back of the target address then shows that nothing was stored.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;

    localparam int PTR_W   = 8;
    localparam int NSPACE  = 2;
    localparam logic [6:0] ID_CTRL = 7'b1101111;
    localparam logic [6:0] ID_USER = 7'b1010111;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RX,
        ST_DECIDE,
        ST_ACK,
        ST_TX,
        ST_MACK
    } tgt_state_t;

    typedef enum logic [1:0] {
        K_ID,
        K_WADDR,
        K_WDATA
    } rx_kind_t;

    typedef struct packed {
        logic scl;
        logic sda;
        logic scl_rise;
        logic scl_fall;
        logic start;
        logic stop;
    } bus_ev_t;

    typedef struct packed {
        logic hit;
        logic space;
    } id_hit_t;

    function automatic id_hit_t id_decode(input logic [6:0] id);
        id_hit_t r;
        r.hit   = (id == ID_CTRL) || (id == ID_USER);
        r.space = (id == ID_USER);
        return r;
    endfunction

endpackage

// File: rtl/i2c_line_sense.sv
module i2c_line_sense
    import i2c_tgt_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    scl_i,
    input  logic    sda_i,
    output bus_ev_t ev
);
    logic [2:0] scl_pipe;
    logic [2:0] sda_pipe;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_pipe <= 3'b111;
            sda_pipe <= 3'b111;
        end else begin
            scl_pipe <= {scl_pipe[1:0], scl_i};
            sda_pipe <= {sda_pipe[1:0], sda_i};
        end
    end

    always_comb begin
        ev.scl      = scl_pipe[1];
        ev.sda      = sda_pipe[1];
        ev.scl_rise = scl_pipe[1] & ~scl_pipe[2];
        ev.scl_fall = ~scl_pipe[1] & scl_pipe[2];
        ev.start    = scl_pipe[1] & scl_pipe[2] & sda_pipe[2] & ~sda_pipe[1];
        ev.stop     = scl_pipe[1] & scl_pipe[2] & ~sda_pipe[2] & sda_pipe[1];
    end
endmodule

// File: rtl/i2c_dual_store.sv
module i2c_dual_store
    import i2c_tgt_pkg::*;
#(
    parameter int AW = PTR_W
) (
    input  logic          clk,
    input  logic          wr_en,
    input  logic          wr_space,
    input  logic [AW-1:0] wr_addr,
    input  logic [7:0]    wr_data,
    input  logic          rd_space,
    input  logic [AW-1:0] rd_addr,
    output logic [7:0]    rd_data
);
    localparam int DEPTH = 1 << AW;

    logic [7:0] bank_q [NSPACE];

    for (genvar g = 0; g < NSPACE; g++) begin : g_space
        logic [7:0] cells [DEPTH];
        always_ff @(posedge clk) begin
            if (wr_en && (wr_space == 1'(g)))
                cells[wr_addr] <= wr_data;
        end
        assign bank_q[g] = cells[rd_addr];
    end

    assign rd_data = bank_q[rd_space];
endmodule

// File: rtl/i2c_tgt_seq.sv
module i2c_tgt_seq
    import i2c_tgt_pkg::*;
#(
    parameter int AW = PTR_W
) (
    input  logic          clk,
    input  logic          rst,
    input  bus_ev_t       ev,
    input  logic [7:0]    rd_data,
    output logic          wr_en,
    output logic          wr_space,
    output logic [AW-1:0] wr_addr,
    output logic [7:0]    wr_data,
    output logic          rd_space,
    output logic [AW-1:0] rd_addr,
    output logic          sda_oe
);
    tgt_state_t    state;
    rx_kind_t      kind;
    logic [2:0]    bit_cnt;
    logic [7:0]    shreg;
    logic [7:0]    tx_byte;
    logic          tx_last;
    logic          mack_ok;
    logic          ack_pend;
    logic          rd_dir;
    logic          space;
    logic          rs_pend;
    logic          rs_space;
    logic [AW-1:0] ptr;
    logic          oe_q;

    logic [7:0] rx_byte;
    logic       byte_done;
    id_hit_t    idh;
    logic       id_ok;

    always_comb begin
        rx_byte   = {shreg[6:0], ev.sda};
        byte_done = (state == ST_RX) && ev.scl_rise && (bit_cnt == 3'd7);
        idh       = id_decode(rx_byte[7:1]);
        id_ok     = idh.hit && !(rx_byte[0] && rs_pend && (idh.space != rs_space));
        wr_en     = byte_done && (kind == K_WDATA);
        wr_space  = space;
        wr_addr   = ptr;
        wr_data   = rx_byte;
        rd_space  = space;
        rd_addr   = ptr;
        sda_oe    = oe_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            kind     <= K_ID;
            bit_cnt  <= '0;
            shreg    <= '0;
            tx_byte  <= '0;
            tx_last  <= 1'b0;
            mack_ok  <= 1'b0;
            ack_pend <= 1'b0;
            rd_dir   <= 1'b0;
            space    <= 1'b0;
            rs_pend  <= 1'b0;
            rs_space <= 1'b0;
            ptr      <= '0;
            oe_q     <= 1'b0;
        end else if (ev.start) begin
            state   <= ST_RX;
            kind    <= K_ID;
            bit_cnt <= '0;
            tx_last <= 1'b0;
            oe_q    <= 1'b0;
        end else if (ev.stop) begin
            state   <= ST_IDLE;
            rs_pend <= 1'b0;
            tx_last <= 1'b0;
            oe_q    <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: oe_q <= 1'b0;
                ST_RX: begin
                    if (ev.scl_rise) begin
                        shreg   <= rx_byte;
                        bit_cnt <= bit_cnt + 3'd1;
                    end
                    if (byte_done) begin
                        state <= ST_DECIDE;
                        case (kind)
                            K_ID: begin
                                ack_pend <= id_ok;
                                rs_pend  <= 1'b0;
                                if (id_ok) begin
                                    space  <= idh.space;
                                    rd_dir <= rx_byte[0];
                                end
                            end
                            K_WADDR: begin
                                ack_pend <= 1'b1;
                                ptr      <= rx_byte[AW-1:0];
                                rs_pend  <= 1'b1;
                                rs_space <= space;
                            end
                            default: begin
                                ack_pend <= 1'b1;
                                rs_pend  <= 1'b0;
                                ptr      <= ptr + 1'b1;
                            end
                        endcase
                    end
                end
                ST_DECIDE: begin
                    if (ev.scl_fall) begin
                        if (ack_pend) begin
                            oe_q  <= 1'b1;
                            state <= ST_ACK;
                        end else begin
                            oe_q  <= 1'b0;
                            state <= ST_IDLE;
                        end
                    end
                end
                ST_ACK: begin
                    if (ev.scl_fall) begin
                        bit_cnt <= '0;
                        if (kind == K_ID && rd_dir) begin
                            tx_byte <= rd_data;
                            oe_q    <= ~rd_data[7];
                            ptr     <= ptr + 1'b1;
                            state   <= ST_TX;
                        end else begin
                            oe_q  <= 1'b0;
                            state <= ST_RX;
                            kind  <= (kind == K_ID) ? K_WADDR : K_WDATA;
                        end
                    end
                end
                ST_TX: begin
                    if (ev.scl_rise) begin
                        if (bit_cnt == 3'd7) tx_last <= 1'b1;
                        else                 bit_cnt <= bit_cnt + 3'd1;
                    end else if (ev.scl_fall) begin
                        if (tx_last) begin
                            tx_last <= 1'b0;
                            oe_q    <= 1'b0;
                            state   <= ST_MACK;
                        end else begin
                            tx_byte <= {tx_byte[6:0], 1'b0};
                            oe_q    <= ~tx_byte[6];
                        end
                    end
                end
                ST_MACK: begin
                    if (ev.scl_rise) begin
                        mack_ok <= ~ev.sda;
                    end else if (ev.scl_fall) begin
                        bit_cnt <= '0;
                        if (mack_ok) begin
                            tx_byte <= rd_data;
                            oe_q    <= ~rd_data[7];
                            ptr     <= ptr + 1'b1;
                            state   <= ST_TX;
                        end else begin
                            oe_q  <= 1'b0;
                            state <= ST_IDLE;
                        end
                    end
                end
                default: begin
                    state <= ST_IDLE;
                    oe_q  <= 1'b0;
                end
            endcase
        end
    end

    // R2, R8: an idle target never holds the line
    a_r2_idle_released: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE) |-> !sda_oe);

    // R10: the line is free in the cycle after a stop is seen
    a_r10_stop_releases: assert property (@(posedge clk) disable iff (rst)
        ev.stop |=> !sda_oe);

    // R10: the drive only moves while the synchronised clock is low
    a_r10_oe_scl_low: assert property (@(posedge clk) disable iff (rst)
        (sda_oe != $past(sda_oe)) |-> (!$past(ev.scl) || $past(ev.start) || $past(ev.stop)));

    // R4: a store at the top address wraps the pointer to zero
    a_r4_ptr_wrap: assert property (@(posedge clk) disable iff (rst)
        (wr_en && (wr_addr == {AW{1'b1}}) && !ev.start && !ev.stop) |=> (rd_addr == '0));
endmodule

// File: rtl/dual_id_i2c_target.sv
module dual_id_i2c_target
    import i2c_tgt_pkg::*;
#(
    parameter int AW = PTR_W
) (
    input  logic clk,
    input  logic rst,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_oe
);
    bus_ev_t       ev;
    logic          wr_en;
    logic          wr_space;
    logic [AW-1:0] wr_addr;
    logic [7:0]    wr_data;
    logic          rd_space;
    logic [AW-1:0] rd_addr;
    logic [7:0]    rd_data;

    i2c_line_sense u_sense (
        .clk   (clk),
        .rst   (rst),
        .scl_i (scl_i),
        .sda_i (sda_i),
        .ev    (ev)
    );

    i2c_tgt_seq #(.AW(AW)) u_seq (
        .clk      (clk),
        .rst      (rst),
        .ev       (ev),
        .rd_data  (rd_data),
        .wr_en    (wr_en),
        .wr_space (wr_space),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .rd_space (rd_space),
        .rd_addr  (rd_addr),
        .sda_oe   (sda_oe)
    );

    i2c_dual_store #(.AW(AW)) u_store (
        .clk      (clk),
        .wr_en    (wr_en),
        .wr_space (wr_space),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .rd_space (rd_space),
        .rd_addr  (rd_addr),
        .rd_data  (rd_data)
    );
endmodule

// File: tb/sim_dual_id_i2c_target.sv
`timescale 1ns/1ps
module sim_dual_id_i2c_target;
    localparam int Q = 10;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic m_scl = 1'b1;
    logic m_sdal = 1'b0;
    logic sda_oe;
    logic sda_line;

    int checks = 0;
    int errors = 0;
    int r10_bad = 0;
    logic oe_prev = 1'b0;

    always #5 clk = ~clk;
    assign sda_line = ~(sda_oe | m_sdal);

    dual_id_i2c_target u0 (
        .clk    (clk),
        .rst    (rst),
        .scl_i  (m_scl),
        .sda_i  (sda_line),
        .sda_oe (sda_oe)
    );

    // R10 monitor: drive may change only while the bus clock is low
    always @(negedge clk) begin
        if (!rst && (sda_oe != oe_prev) && m_scl) r10_bad++;
        oe_prev <= sda_oe;
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wq();
        repeat (Q) @(negedge clk);
    endtask

    task automatic m_start();
        m_sdal = 1'b0; wq();
        m_scl  = 1'b1; wq();
        m_sdal = 1'b1; wq();
        m_scl  = 1'b0; wq();
    endtask

    task automatic m_stop();
        m_sdal = 1'b1; wq();
        m_scl  = 1'b1; wq();
        m_sdal = 1'b0; wq();
    endtask

    task automatic m_bits(input int n, input logic [7:0] b);
        for (int i = 7; i > 7 - n; i--) begin
            m_sdal = ~b[i]; wq();
            m_scl  = 1'b1;  wq();
            m_scl  = 1'b0;  wq();
        end
    endtask

    task automatic m_wr(input logic [7:0] b, output logic ack);
        m_bits(8, b);
        m_sdal = 1'b0; wq();
        m_scl  = 1'b1; wq();
        ack    = ~sda_line;
        wq();
        m_scl  = 1'b0; wq();
    endtask

    task automatic m_rd(input logic give_ack, output logic [7:0] b);
        m_sdal = 1'b0;
        for (int i = 7; i >= 0; i--) begin
            wq();
            m_scl = 1'b1; wq();
            b[i]  = sda_line;
            wq();
            m_scl = 1'b0;
        end
        wq();
        m_sdal = give_ack; wq();
        m_scl  = 1'b1; wq(); wq();
        m_scl  = 1'b0; wq();
        m_sdal = 1'b0;
    endtask

    task automatic do_write(input logic [7:0] id, input logic [7:0] addr,
                            input logic [7:0] d0, input int n,
                            input logic [7:0] d1, input logic [7:0] d2);
        logic a;
        logic [7:0] dv [3];
        dv[0] = d0; dv[1] = d1; dv[2] = d2;
        m_start();
        m_wr(id, a);   check(a, "R3 id ack", a, 1);
        m_wr(addr, a); check(a, "R3 addr ack", a, 1);
        for (int k = 0; k < n; k++) begin
            m_wr(dv[k], a); check(a, "R3 data ack", a, 1);
        end
        m_stop();
    endtask

    task automatic rand_read(input logic [7:0] id, input logic [7:0] addr, input int n,
                             input logic [7:0] e0, input logic [7:0] e1, input logic [7:0] e2,
                             input string req);
        logic a;
        logic [7:0] got;
        logic [7:0] ev [3];
        ev[0] = e0; ev[1] = e1; ev[2] = e2;
        m_start();
        m_wr(id, a);
        m_wr(addr, a);
        m_start();
        m_wr(id | 8'h01, a); check(a, "R6 read id ack", a, 1);
        for (int k = 0; k < n; k++) begin
            m_rd(k != n - 1, got);
            check(got == ev[k], req, got, ev[k]);
        end
        m_stop();
    endtask

    task automatic t_reset_state();
        check(sda_oe == 1'b0, "R10 released after reset", sda_oe, 0);
    endtask

    task automatic t_current_after_reset();
        logic a;
        logic [7:0] got;
        do_write(8'hDE, 8'h00, 8'h3C, 2, 8'h77, 8'h00);
        @(negedge clk); rst = 1'b1;
        repeat (4) @(negedge clk); rst = 1'b0;
        repeat (4) @(negedge clk);
        m_start();
        m_wr(8'hDF, a); check(a, "R5 read id ack", a, 1);
        m_rd(1'b0, got);
        check(got == 8'h3C, "R5 current read at 00", got, 8'h3C);
        m_stop();
    endtask

    task automatic t_two_spaces();
        do_write(8'hDE, 8'h05, 8'h5A, 1, 8'h00, 8'h00);
        do_write(8'hAE, 8'h05, 8'hA5, 1, 8'h00, 8'h00);
        rand_read(8'hDE, 8'h05, 1, 8'h5A, 8'h00, 8'h00, "R1 ctrl space 05");
        rand_read(8'hAE, 8'h05, 1, 8'hA5, 8'h00, 8'h00, "R1 user space 05");
    endtask

    task automatic t_wrong_id();
        logic a;
        m_start();
        m_wr(8'h90, a); check(!a, "R2 unknown id nack", a, 0);
        m_wr(8'h05, a); check(!a, "R2 line stays released", a, 0);
        m_wr(8'h00, a); check(!a, "R2 line stays released", a, 0);
        m_stop();
        rand_read(8'hDE, 8'h05, 1, 8'h5A, 8'h00, 8'h00, "R2 store untouched");
    endtask

    task automatic t_mismatch();
        logic a;
        m_start();
        m_wr(8'hDE, a);
        m_wr(8'h05, a);
        m_start();
        m_wr(8'hAF, a); check(!a, "R7 mismatched read id nack", a, 0);
        m_stop();
    endtask

    task automatic t_burst_wrap();
        logic [7:0] got;
        do_write(8'hAE, 8'hFE, 8'h11, 3, 8'h22, 8'h33);
        rand_read(8'hAE, 8'hFE, 3, 8'h11, 8'h22, 8'h33, "R4 R8 burst across wrap");
        rand_read(8'hDE, 8'h00, 1, 8'h3C, 8'h00, 8'h00, "R4 ctrl 00 untouched by wrap");
        // after the final NACK the target must stay off the line
        m_start();
        begin
            logic a;
            m_wr(8'hAF, a);
            m_rd(1'b0, got);
        end
        m_rd(1'b0, got);
        check(got == 8'hFF, "R8 released after nack", got, 8'hFF);
        m_stop();
    endtask

    task automatic t_abort();
        logic a;
        do_write(8'hAE, 8'h10, 8'hAA, 1, 8'h00, 8'h00);
        m_start();
        m_wr(8'hAE, a);
        m_wr(8'h10, a);
        m_bits(4, 8'h55);
        m_stop();
        rand_read(8'hAE, 8'h10, 1, 8'hAA, 8'h00, 8'h00, "R9 stop mid byte");
        m_start();
        m_wr(8'hAE, a);
        m_wr(8'h10, a);
        m_bits(3, 8'h00);
        m_start();
        m_wr(8'hAF, a); check(a, "R9 start mid byte resyncs", a, 1);
        m_rd(1'b0, a ? got_dummy : got_dummy);
        m_stop();
        rand_read(8'hAE, 8'h10, 1, 8'hAA, 8'h00, 8'h00, "R9 start mid byte");
    endtask

    logic [7:0] got_dummy;

    initial begin
        repeat (5) @(negedge clk);
        rst = 1'b0;
        repeat (5) @(negedge clk);
        t_reset_state();
        t_current_after_reset();
        t_two_spaces();
        t_wrong_id();
        t_mismatch();
        t_burst_wrap();
        t_abort();
        check(r10_bad == 0, "R10 drive changes only with SCL low", r10_bad, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule